// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block keeps the machine-level control and status registers of a small 32-bit core and carries out trap entry. Software reaches the registers through a single access port: a 12-bit register address, 32-bit write data and a write enable. The read data is combinational on the address. The ISA-description register is a fixed constant. The machine status register starts out holding the 32-bit XLEN code. A group of general registers (trap vector, scratch, exception PC, cause and trap value) acts as plain storage.

When the pipeline raises a trap request, it presents a cause code, the PC of the trapping instruction and the instruction word. On the next clock edge the block fills the exception PC, cause and trap-value registers. One cycle later it presents a redirect PC, taken from the trap-vector register, together with a one-cycle valid strobe. A single free-running 64-bit counter feeds the cycle, machine-cycle and time views. Writes through the machine-cycle addresses load its halves.

Top module: `mcsr_trap_unit`

## Requirements
- R1: Reading address 0x301 (ISA description) returns 0x40001105 from reset onwards. That value is the XLEN code 1 in bits 31:30 plus the extension bits 0, 2, 8 and 12.
- R2: A write to address 0x301 has no effect: later reads still return 0x40001105.
- R3: The machine status register (0x300) resets to 0x40000000 and then behaves as 32-bit read/write storage.
- R4: A shared 64-bit counter clears on reset and increments by one on every clock. Addresses 0xC00, 0xB00 and 0xC01 read its low 32 bits. Addresses 0xC80, 0xB80 and 0xC81 read its high 32 bits.
- R5: A write to 0xB00 loads the counter's low half, and a write to 0xB80 loads its high half; the value written is read back on the next cycle. Counting then resumes, and an overflow of the low half carries into the high half.
- R6: When a trap request is sampled at a clock edge, the exception PC register (0x341) takes the trap PC and the cause register (0x342) takes the trap cause.
- R7: On trap entry, the trap-value register (0x343) takes the instruction word when the cause equals 2 (illegal instruction), and the trap PC for every other cause.
- R8: After each clock edge that samples a trap request, the redirect valid output is high for the next cycle only. The redirect PC then equals the trap-vector register (0x305) as it was before that edge.
- R9: When a trap and a software write to the same trap register fall in the same cycle, the trap's value is stored.
- R10: The trap vector (reset 0), scratch (0x340), exception PC, cause and trap-value registers behave as 32-bit read/write storage. Any unmapped address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address for read and write |
| csr_wdata | input | 32 | Write data |
| csr_we | input | 1 | Write enable |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| trap_req | input | 1 | Trap entry request, one per cycle held high |
| trap_cause | input | 32 | Cause code of the trap |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_insn | input | 32 | Instruction word of the trapping instruction |
| redirect_pc | output | 32 | Fetch redirect target |
| redirect_valid | output | 1 | One-cycle strobe marking redirect_pc valid |

## Verification
The hardest case to reach is the carry from the counter's low half into its high half, because it would naturally take four billion clocks. The stimulus loads the low half with a value a few counts below overflow through the machine-cycle write address. It then reads both halves on the cycles that follow. The same-cycle collisions are also driven on purpose: a trap together with a software write to the exception PC, and a trap together with a rewrite of the trap vector. This shows both the priority rule and that the redirect uses the old vector.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

   localparam logic [11:0] ADR_MSTATUS  = 12'h300;
   localparam logic [11:0] ADR_MISA     = 12'h301;
   localparam logic [11:0] ADR_MTVEC    = 12'h305;
   localparam logic [11:0] ADR_MSCRATCH = 12'h340;
   localparam logic [11:0] ADR_MEPC     = 12'h341;
   localparam logic [11:0] ADR_MCAUSE   = 12'h342;
   localparam logic [11:0] ADR_MTVAL    = 12'h343;
   localparam logic [11:0] ADR_MCYC_LO  = 12'hB00;
   localparam logic [11:0] ADR_MCYC_HI  = 12'hB80;
   localparam logic [11:0] ADR_CYC_LO   = 12'hC00;
   localparam logic [11:0] ADR_TIM_LO   = 12'hC01;
   localparam logic [11:0] ADR_CYC_HI   = 12'hC80;
   localparam logic [11:0] ADR_TIM_HI   = 12'hC81;

   // XLEN code for a 32-bit machine, placed in the top two bits
   function automatic logic [31:0] xlen_field();
      return 32'h4000_0000;
   endfunction

   // base integer, multiply, atomic and compressed extension bits
   function automatic logic [31:0] isa_word();
      return xlen_field() | (32'h1 << 8) | (32'h1 << 12) | (32'h1 << 0) | (32'h1 << 2);
   endfunction

endpackage

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
   parameter int CNT_W    = 64,
   parameter bit WRITABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_lo,
   input  logic               ld_hi,
   input  logic [CNT_W/2-1:0] ld_data,
   output logic [CNT_W-1:0]   count
);
   localparam int HW = CNT_W / 2;

   if (CNT_W % 2 != 0) begin : g_bad_width
      $error("mcsr_counter: CNT_W must be even");
   end

   if (WRITABLE) begin : g_loadable
      always_ff @(posedge clk) begin
         if (!rst_n)     count <= '0;
         else if (ld_lo) count <= {count[CNT_W-1:HW], ld_data};
         else if (ld_hi) count <= {ld_data, count[HW-1:0]};
         else            count <= count + 1'b1;
      end

      a_r4_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
         (!ld_lo && !ld_hi) |=> (count == $past(count) + 1'b1));
      a_r5_low_load: assert property (@(posedge clk) disable iff (!rst_n)
         ld_lo |=> (count[HW-1:0] == $past(ld_data)));
   end else begin : g_fixed
      logic unused_ld;
      assign unused_ld = ^{ld_lo, ld_hi, ld_data};
      always_ff @(posedge clk) begin
         if (!rst_n) count <= '0;
         else        count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/mcsr_trap_regs.sv
module mcsr_trap_regs
   import mcsr_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter int          ADDR_W        = 12,
   parameter logic [31:0] ILLEGAL_CAUSE = 32'd2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic              trap_req,
   input  logic [XLEN-1:0]   trap_cause,
   input  logic [XLEN-1:0]   trap_pc,
   input  logic [XLEN-1:0]   trap_insn,
   output logic [XLEN-1:0]   r_status,
   output logic [XLEN-1:0]   r_tvec,
   output logic [XLEN-1:0]   r_scratch,
   output logic [XLEN-1:0]   r_epc,
   output logic [XLEN-1:0]   r_cause,
   output logic [XLEN-1:0]   r_tval,
   output logic [XLEN-1:0]   redirect_pc,
   output logic              redirect_valid
);
   logic wr_status, wr_tvec, wr_scratch, wr_epc, wr_cause, wr_tval;
   logic is_illegal;

   assign wr_status  = csr_we && (csr_addr == ADR_MSTATUS);
   assign wr_tvec    = csr_we && (csr_addr == ADR_MTVEC);
   assign wr_scratch = csr_we && (csr_addr == ADR_MSCRATCH);
   assign wr_epc     = csr_we && (csr_addr == ADR_MEPC);
   assign wr_cause   = csr_we && (csr_addr == ADR_MCAUSE);
   assign wr_tval    = csr_we && (csr_addr == ADR_MTVAL);
   assign is_illegal = (trap_cause == ILLEGAL_CAUSE[XLEN-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_status       <= xlen_field();
         r_tvec         <= '0;
         r_scratch      <= '0;
         r_epc          <= '0;
         r_cause        <= '0;
         r_tval         <= '0;
         redirect_pc    <= '0;
         redirect_valid <= 1'b0;
      end else begin
         if (wr_status)  r_status  <= csr_wdata;
         if (wr_tvec)    r_tvec    <= csr_wdata;
         if (wr_scratch) r_scratch <= csr_wdata;
         if (wr_epc)     r_epc     <= csr_wdata;
         if (wr_cause)   r_cause   <= csr_wdata;
         if (wr_tval)    r_tval    <= csr_wdata;
         // trap updates come last so they win over a same-cycle write
         if (trap_req) begin
            r_epc       <= trap_pc;
            r_cause     <= trap_cause;
            r_tval      <= is_illegal ? trap_insn : trap_pc;
            redirect_pc <= r_tvec;
         end
         redirect_valid <= trap_req;
      end
   end

   a_r6_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (r_epc == $past(trap_pc) && r_cause == $past(trap_cause)));
   a_r7_tval_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && trap_cause == ILLEGAL_CAUSE[XLEN-1:0]) |=> (r_tval == $past(trap_insn)));
   a_r7_tval_other: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && trap_cause != ILLEGAL_CAUSE[XLEN-1:0]) |=> (r_tval == $past(trap_pc)));
   a_r8_strobe_after_trap: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (redirect_valid && redirect_pc == $past(r_tvec)));
   a_r8_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |=> !redirect_valid);

endmodule

// File: rtl/mcsr_read_mux.sv
module mcsr_read_mux
   import mcsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ADDR_W = 12,
   parameter int CNT_W  = 64
) (
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [XLEN-1:0]   r_status,
   input  logic [XLEN-1:0]   r_tvec,
   input  logic [XLEN-1:0]   r_scratch,
   input  logic [XLEN-1:0]   r_epc,
   input  logic [XLEN-1:0]   r_cause,
   input  logic [XLEN-1:0]   r_tval,
   input  logic [CNT_W-1:0]  count,
   output logic [XLEN-1:0]   csr_rdata
);
   localparam int HW = CNT_W / 2;

   if (HW != XLEN) begin : g_bad_split
      $error("mcsr_read_mux: counter halves must match XLEN");
   end

   always_comb begin
      unique case (csr_addr)
         ADR_MISA:                             csr_rdata = isa_word();
         ADR_MSTATUS:                          csr_rdata = r_status;
         ADR_MTVEC:                            csr_rdata = r_tvec;
         ADR_MSCRATCH:                         csr_rdata = r_scratch;
         ADR_MEPC:                             csr_rdata = r_epc;
         ADR_MCAUSE:                           csr_rdata = r_cause;
         ADR_MTVAL:                            csr_rdata = r_tval;
         ADR_CYC_LO, ADR_MCYC_LO, ADR_TIM_LO: csr_rdata = count[HW-1:0];
         ADR_CYC_HI, ADR_MCYC_HI, ADR_TIM_HI: csr_rdata = count[CNT_W-1:HW];
         default:                              csr_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
   import mcsr_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter int          ADDR_W        = 12,
   parameter bit          CNT_WRITABLE  = 1'b1,
   parameter logic [31:0] ILLEGAL_CAUSE = 32'd2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic              csr_we,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic              trap_req,
   input  logic [XLEN-1:0]   trap_cause,
   input  logic [XLEN-1:0]   trap_pc,
   input  logic [XLEN-1:0]   trap_insn,
   output logic [XLEN-1:0]   redirect_pc,
   output logic              redirect_valid
);
   localparam int CNT_W = 2 * XLEN;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mcsr_trap_unit: only XLEN = 32 is supported");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("mcsr_trap_unit: ADDR_W must be 12");
   end

   logic [XLEN-1:0]  r_status, r_tvec, r_scratch, r_epc, r_cause, r_tval;
   logic [CNT_W-1:0] count;
   logic             ld_lo, ld_hi;

   assign ld_lo = csr_we && (csr_addr == ADR_MCYC_LO);
   assign ld_hi = csr_we && (csr_addr == ADR_MCYC_HI);

   mcsr_counter #(.CNT_W(CNT_W), .WRITABLE(CNT_WRITABLE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi),
      .ld_data(csr_wdata), .count(count)
   );

   mcsr_trap_regs #(.XLEN(XLEN), .ADDR_W(ADDR_W), .ILLEGAL_CAUSE(ILLEGAL_CAUSE)) u_regs (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .trap_req(trap_req), .trap_cause(trap_cause),
      .trap_pc(trap_pc), .trap_insn(trap_insn), .r_status(r_status),
      .r_tvec(r_tvec), .r_scratch(r_scratch), .r_epc(r_epc), .r_cause(r_cause),
      .r_tval(r_tval), .redirect_pc(redirect_pc), .redirect_valid(redirect_valid)
   );

   mcsr_read_mux #(.XLEN(XLEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
      .csr_addr(csr_addr), .r_status(r_status), .r_tvec(r_tvec),
      .r_scratch(r_scratch), .r_epc(r_epc), .r_cause(r_cause), .r_tval(r_tval),
      .count(count), .csr_rdata(csr_rdata)
   );

   a_r2_isa_constant: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == ADR_MISA) |-> (csr_rdata == 32'h4000_1105));
   a_r9_trap_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && csr_we && csr_addr == ADR_MEPC) |=> (u_regs.r_epc == $past(trap_pc)));

endmodule

// File: tb/mcsr_trap_unit_tb_top.sv
module mcsr_trap_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_rdata;
   logic        trap_req = 1'b0;
   logic [31:0] trap_cause = '0;
   logic [31:0] trap_pc = '0;
   logic [31:0] trap_insn = '0;
   logic [31:0] redirect_pc;
   logic        redirect_valid;

   int tests = 0;
   int fails = 0;

   // reference state
   longint unsigned m_cnt = 0;
   logic [31:0] m_status = 32'h4000_0000, m_tvec = 0, m_scratch = 0;
   logic [31:0] m_epc = 0, m_cause = 0, m_tval = 0;
   logic [31:0] m_rpc = 0;
   logic        m_rv = 1'b0;

   always #2 clk = ~clk;

   mcsr_trap_unit dut_i (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_we(csr_we), .csr_rdata(csr_rdata), .trap_req(trap_req),
      .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_insn(trap_insn),
      .redirect_pc(redirect_pc), .redirect_valid(redirect_valid)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [11:0] a);
      case (a)
         12'h301: return 32'h4000_1105;
         12'h300: return m_status;
         12'h305: return m_tvec;
         12'h340: return m_scratch;
         12'h341: return m_epc;
         12'h342: return m_cause;
         12'h343: return m_tval;
         12'hC00, 12'hB00, 12'hC01: return m_cnt[31:0];
         12'hC80, 12'hB80, 12'hC81: return m_cnt[63:32];
         default: return 32'h0;
      endcase
   endfunction

   // one clock: drive at negedge, check read, model the edge, check redirect
   task automatic cyc(input string tag, input logic we, input logic [11:0] a,
                      input logic [31:0] wd, input logic tr = 1'b0,
                      input logic [31:0] cause = 0, input logic [31:0] pc = 0,
                      input logic [31:0] insn = 0);
      logic [31:0] old_tvec;
      csr_we = we; csr_addr = a; csr_wdata = wd;
      trap_req = tr; trap_cause = cause; trap_pc = pc; trap_insn = insn;
      #1;
      chk(tag, csr_rdata, m_read(a));
      @(posedge clk);
      old_tvec = m_tvec;
      if (we && a == 12'hB00)      m_cnt = {m_cnt[63:32], wd};
      else if (we && a == 12'hB80) m_cnt = {wd, m_cnt[31:0]};
      else                         m_cnt = m_cnt + 1;
      if (we) begin
         case (a)
            12'h300: m_status  = wd;
            12'h305: m_tvec    = wd;
            12'h340: m_scratch = wd;
            12'h341: m_epc     = wd;
            12'h342: m_cause   = wd;
            12'h343: m_tval    = wd;
            default: ;
         endcase
      end
      if (tr) begin
         m_epc   = pc;
         m_cause = cause;
         m_tval  = (cause == 32'd2) ? insn : pc;
         m_rpc   = old_tvec;
      end
      m_rv = tr;
      @(negedge clk);
      chk("R8 redirect_valid", {31'b0, redirect_valid}, {31'b0, m_rv});
      if (m_rv) chk("R8 redirect_pc", redirect_pc, m_rpc);
   endtask

   task automatic rd(input string tag, input logic [11:0] a);
      cyc(tag, 1'b0, a, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 R3 R10 R4 reset state
      rd("R1 isa reset", 12'h301);
      rd("R3 status reset", 12'h300);
      rd("R10 tvec reset", 12'h305);
      rd("R4 cycle low", 12'hC00);
      rd("R4 cycle high", 12'hC80);
      // R2 isa writes ignored
      cyc("R2 isa write", 1'b1, 12'h301, 32'h0);
      rd("R2 isa after write", 12'h301);
      cyc("R2 isa write ones", 1'b1, 12'h301, 32'hFFFF_FFFF);
      rd("R2 isa after ones", 12'h301);
      // R3 R10 plain storage
      cyc("R3 status write", 1'b1, 12'h300, 32'h0000_1888);
      rd("R3 status read", 12'h300);
      cyc("R10 tvec write", 1'b1, 12'h305, 32'h0000_0100);
      rd("R10 tvec read", 12'h305);
      cyc("R10 scratch write", 1'b1, 12'h340, 32'hA5A5_5A5A);
      rd("R10 scratch read", 12'h340);
      cyc("R10 tval write", 1'b1, 12'h343, 32'h1234_5678);
      rd("R10 tval read", 12'h343);
      // R10 unmapped
      cyc("R10 unmapped write", 1'b1, 12'h7C0, 32'hFFFF_FFFF);
      rd("R10 unmapped read", 12'h7C0);
      // R4 all counter views
      rd("R4 mcycle", 12'hB00);
      rd("R4 time", 12'hC01);
      rd("R4 mcycleh", 12'hB80);
      rd("R4 timeh", 12'hC81);
      // R6 R7 illegal-instruction trap
      cyc("R7 trap illegal", 1'b0, 12'h343, 0, 1'b1, 32'd2, 32'h8000_0010, 32'hDEAD_BEEF);
      rd("R7 tval insn", 12'h343);
      rd("R6 epc", 12'h341);
      rd("R6 cause", 12'h342);
      // R7 other causes
      cyc("R7 trap cause5", 1'b0, 12'h000, 0, 1'b1, 32'd5, 32'h8000_0020, 32'h0000_0013);
      rd("R7 tval pc", 12'h343);
      cyc("R7 trap cause0", 1'b0, 12'h000, 0, 1'b1, 32'd0, 32'h8000_0024, 32'hFFFF_FFFF);
      rd("R7 tval pc c0", 12'h343);
      cyc("R6 trap cause11", 1'b0, 12'h000, 0, 1'b1, 32'd11, 32'h8000_0030, 32'h0000_0073);
      rd("R6 cause11", 12'h342);
      // R9 trap collides with writes to its registers
      cyc("R9 trap+epc write", 1'b1, 12'h341, 32'h1111_1111, 1'b1, 32'd2, 32'h8000_0040, 32'hCAFE_F00D);
      rd("R9 epc", 12'h341);
      cyc("R9 trap+cause write", 1'b1, 12'h342, 32'h2222_2222, 1'b1, 32'd7, 32'h8000_0044, 32'h0);
      rd("R9 cause", 12'h342);
      cyc("R9 trap+tval write", 1'b1, 12'h343, 32'h3333_3333, 1'b1, 32'd2, 32'h8000_0048, 32'h0BAD_0BAD);
      rd("R9 tval", 12'h343);
      // R8 trap with same-cycle vector rewrite uses old vector
      cyc("R8 trap+tvec write", 1'b1, 12'h305, 32'h0000_0200, 1'b1, 32'd3, 32'h8000_0050, 32'h0);
      rd("R8 tvec new", 12'h305);
      // R8 back-to-back traps
      cyc("R8 trap a", 1'b0, 12'h341, 0, 1'b1, 32'd1, 32'h8000_0060, 32'h0);
      cyc("R8 trap b", 1'b0, 12'h341, 0, 1'b1, 32'd2, 32'h8000_0064, 32'h0000_FFFF);
      rd("R8 idle", 12'h341);
      // R5 counter loads and carry
      cyc("R5 load low", 1'b1, 12'hB00, 32'hFFFF_FFFD);
      for (int i = 0; i < 5; i++) begin
         rd("R5 low near carry", 12'hB00);
         rd("R5 high near carry", 12'hC80);
      end
      cyc("R5 load high", 1'b1, 12'hB80, 32'h0000_0012);
      rd("R5 high loaded", 12'hB80);
      rd("R5 time high", 12'hC81);
      rd("R5 low after", 12'hC00);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule